// File: doc/BRIEF.md
# Write-only I2C frame receiver

This block is an I2C target that only accepts writes. It oversamples the serial clock and data lines with the system clock, finds bus start, repeated start and stop conditions, and compares the 7-bit address that follows against two values. One is a local address chosen by three ternary strap inputs. The other is a fixed broadcast address that every instance answers. When a write is addressed to it, the block acknowledges the address and exactly three data bytes. It then hands the assembled 24-bit word to the surrounding logic on a single-cycle strobe.

The block never answers a read, and it refuses any byte beyond the third. A start or stop that arrives part-way through a frame throws the partial word away. A repeated start begins address reception again. The block drives the data line only as an open-drain pull-down, through an output enable. A reduced-strap build looks at the first strap only.

Top module: `i2c_write_target`

## Requirements
- R1: After reset, `sdaOe` and `wordValid` are 0 and `wordData` is zero.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Data bits are taken on SCL rising edges, most significant bit first, and the eighth bit of the address byte is the read/write flag (0 = write).
- R3: Each strap input is a 2-bit level code: 0 = ground, 1 = open, 2 = supply, and 3 is treated as supply. With levels v2, v1, v0 the index is i = 9*v2 + 3*v1 + v0. The local address is {i/4 + 1 (3 bits), 2'b00, i mod 4 (2 bits)}, and a write to it is acknowledged in the ninth clock.
- R4: A write to the broadcast address 7'h73 is acknowledged regardless of the straps.
- R5: A write to any other address is not acknowledged. SDA stays released, and no word is produced for that frame.
- R6: A read (flag = 1) is never acknowledged, even to the local or broadcast address, and produces no word.
- R7: After an accepted address, the first three data bytes are each acknowledged. At the end of the third acknowledge clock, `wordValid` pulses for exactly one cycle, with `wordData` = {byte1, byte2, byte3} held stable.
- R8: Every data byte after the third in the same frame is not acknowledged and produces no further word.
- R9: A start or stop before the third byte completes discards the partial frame, and `sdaOe` is released on the cycle after the condition is detected. A repeated start restarts address reception, so a following complete write yields its own word only.
- R10: With `FULL_STRAP` = 0, only `addrStrap0` is used. The local address is 7'h10, 7'h11 or 7'h12 for levels 0, 1 and 2, and the other straps are ignored.
- R11: `sdaOe` is asserted only while SCL is low. It does not change while SCL stays high, except for the release that follows a start or stop. It is released after the falling SCL edge that ends the acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line as seen on the pad |
| sdaIn | input | 1 | Serial data line as seen on the pad |
| addrStrap0 | input | 2 | Strap level code, least significant ternary digit |
| addrStrap1 | input | 2 | Strap level code, middle ternary digit |
| addrStrap2 | input | 2 | Strap level code, most significant ternary digit |
| sdaOe | output | 1 | Pull-down enable for SDA (1 = drive low) |
| wordValid | output | 1 | One-cycle strobe for a completed three-byte word |
| wordData | output | 24 | Received word, first byte in the top bits |

## Verification
Directed frames cover the addressing cases one at a time: the local address, the broadcast address, a foreign address and a read. Each is told apart by the acknowledge seen in the ninth clock and by whether a word appears. Frames carrying zero to five data bytes separate the acknowledged first three bytes from the refused fourth and fifth. Frames cut by a stop inside a byte, or by a repeated start after one byte, show that partial data never leaks into a later word. Randomised straps, including code 3, together with a second reduced-strap instance on the same bus, check the address map and show that the reduced build ignores its upper straps.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  // bus conditions seen on the synchronised lines
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
  } busEvt_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic clrBits;
    logic shiftBit;
    logic captureByte;
    logic emitWord;
  } dpCtl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ACK,
    ST_IGNORE
  } rxState_t;

  // level code 3 is folded onto supply
  function automatic logic [1:0] strapLevel(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

  function automatic logic [6:0] strapAddr(input logic [1:0] s2,
                                           input logic [1:0] s1,
                                           input logic [1:0] s0);
    logic [4:0] idx;
    logic [2:0] hi;
    idx = 5'd9 * {3'b000, strapLevel(s2)}
        + 5'd3 * {3'b000, strapLevel(s1)}
        + {3'b000, strapLevel(s0)};
    hi  = idx[4:2] + 3'd1;
    return {hi, 2'b00, idx[1:0]};
  endfunction

endpackage

// File: rtl/i2cw_datapath.sv
module i2cw_datapath
  import i2cw_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         DATA_BYTES  = 3,
  parameter int         FULL_STRAP  = 1,
  parameter logic [6:0] BCAST_ADDR  = 7'h73
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sclIn,
  input  logic                    sdaIn,
  input  logic [1:0]              addrStrap0,
  input  logic [1:0]              addrStrap1,
  input  logic [1:0]              addrStrap2,
  input  dpCtl_t                  ctl,
  output busEvt_t                 evt,
  output logic                    sclLevel,
  output logic                    bitsFull,
  output logic                    addrHit,
  output logic                    wordValid,
  output logic [8*DATA_BYTES-1:0] wordData
);

  localparam int WORD_W = 8 * DATA_BYTES;
  localparam int BIT_W  = 4;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;
  logic sclNow, sdaNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[SYNC_STAGES-1];
      sdaPrev <= sdaPipe[SYNC_STAGES-1];
    end
  end

  assign sclNow   = sclPipe[SYNC_STAGES-1];
  assign sdaNow   = sdaPipe[SYNC_STAGES-1];
  assign sclLevel = sclNow;

  always_comb begin
    evt.sclRise  = sclNow & ~sclPrev;
    evt.sclFall  = ~sclNow & sclPrev;
    evt.startDet = sclNow & sclPrev & sdaPrev & ~sdaNow;
    evt.stopDet  = sclNow & sclPrev & ~sdaPrev & sdaNow;
  end

  // bit shifter
  logic [7:0]       rxByte;
  logic [BIT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      bitCnt <= '0;
    end else if (ctl.clrBits) begin
      bitCnt <= '0;
    end else if (ctl.shiftBit) begin
      rxByte <= {rxByte[6:0], sdaNow};
      bitCnt <= bitCnt + BIT_W'(1);
    end
  end

  assign bitsFull = (bitCnt == BIT_W'(8));

  // address compare, strap variant picked by parameter
  logic [6:0] localAddr;

  generate
    if (FULL_STRAP != 0) begin : g_fullStrap
      assign localAddr = strapAddr(addrStrap2, addrStrap1, addrStrap0);
    end else begin : g_liteStrap
      logic spareStraps;
      assign spareStraps = ^{addrStrap1, addrStrap2};
      assign localAddr   = strapAddr(2'b00, 2'b00, addrStrap0);
    end
  endgenerate

  assign addrHit = ~rxByte[0] &
                   ((rxByte[7:1] == localAddr) | (rxByte[7:1] == BCAST_ADDR));

  // word assembly
  logic [WORD_W-1:0] wordReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordReg   <= '0;
      wordValid <= 1'b0;
    end else begin
      if (ctl.captureByte) wordReg <= {wordReg[WORD_W-9:0], rxByte};
      wordValid <= ctl.emitWord;
    end
  end

  assign wordData = wordReg;

endmodule

// File: rtl/i2cw_control.sv
module i2cw_control
  import i2cw_pkg::*;
#(
  parameter int DATA_BYTES = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  busEvt_t evt,
  input  logic    bitsFull,
  input  logic    addrHit,
  output dpCtl_t  ctl,
  output logic    sdaOe
);

  localparam int CNT_W = $clog2(DATA_BYTES + 1);

  rxState_t         state;
  logic [CNT_W-1:0] byteCnt;
  logic             sawRise;
  logic             ackForAddr;

  logic receiving, byteDone, dataRoom, ackExit;

  assign receiving = (state == ST_ADDR) || (state == ST_DATA);
  assign byteDone  = receiving && evt.sclFall && bitsFull;
  assign dataRoom  = byteCnt < CNT_W'(DATA_BYTES);
  assign ackExit   = (state == ST_ACK) && evt.sclFall && sawRise;

  always_comb begin
    ctl             = '0;
    ctl.shiftBit    = receiving && evt.sclRise && !bitsFull;
    ctl.captureByte = byteDone && (state == ST_DATA) && dataRoom;
    ctl.clrBits     = evt.startDet || ackExit;
    ctl.emitWord    = ackExit && !ackForAddr && (byteCnt == CNT_W'(DATA_BYTES));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      byteCnt    <= '0;
      sawRise    <= 1'b0;
      ackForAddr <= 1'b0;
      sdaOe      <= 1'b0;
    end else if (evt.startDet) begin
      state   <= ST_ADDR;
      byteCnt <= '0;
      sawRise <= 1'b0;
      sdaOe   <= 1'b0;
    end else if (evt.stopDet) begin
      state   <= ST_IDLE;
      sawRise <= 1'b0;
      sdaOe   <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (byteDone) begin
            if (addrHit) begin
              state      <= ST_ACK;
              ackForAddr <= 1'b1;
              sdaOe      <= 1'b1;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_DATA: begin
          if (byteDone) begin
            if (dataRoom) begin
              state      <= ST_ACK;
              ackForAddr <= 1'b0;
              sdaOe      <= 1'b1;
              byteCnt    <= byteCnt + CNT_W'(1);
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_ACK: begin
          if (evt.sclRise) sawRise <= 1'b1;
          if (ackExit) begin
            state   <= ST_DATA;
            sawRise <= 1'b0;
            sdaOe   <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_write_target.sv
module i2c_write_target
  import i2cw_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         DATA_BYTES  = 3,
  parameter int         FULL_STRAP  = 1,
  parameter logic [6:0] BCAST_ADDR  = 7'h73
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sclIn,
  input  logic                    sdaIn,
  input  logic [1:0]              addrStrap0,
  input  logic [1:0]              addrStrap1,
  input  logic [1:0]              addrStrap2,
  output logic                    sdaOe,
  output logic                    wordValid,
  output logic [8*DATA_BYTES-1:0] wordData
);

  busEvt_t evt;
  dpCtl_t  ctl;
  logic    sclLevel, bitsFull, addrHit;
  logic    startSeen, stopSeen;

  assign startSeen = evt.startDet;
  assign stopSeen  = evt.stopDet;

  i2cw_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .DATA_BYTES (DATA_BYTES),
    .FULL_STRAP (FULL_STRAP),
    .BCAST_ADDR (BCAST_ADDR)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .addrStrap0(addrStrap0),
    .addrStrap1(addrStrap1),
    .addrStrap2(addrStrap2),
    .ctl       (ctl),
    .evt       (evt),
    .sclLevel  (sclLevel),
    .bitsFull  (bitsFull),
    .addrHit   (addrHit),
    .wordValid (wordValid),
    .wordData  (wordData)
  );

  i2cw_control #(
    .DATA_BYTES(DATA_BYTES)
  ) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .evt     (evt),
    .bitsFull(bitsFull),
    .addrHit (addrHit),
    .ctl     (ctl),
    .sdaOe   (sdaOe)
  );

endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker #(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclLevel,
  input logic              startSeen,
  input logic              stopSeen,
  input logic              sdaOe,
  input logic              wordValid,
  input logic [WORD_W-1:0] wordData
);

  p_word_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  p_word_steady_r7: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> $stable(wordData));

  p_start_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> !sdaOe);

  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaOe);

  p_ack_on_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclLevel);

  p_ack_held_high_r11: assert property (@(posedge clk) disable iff (!rstN)
    (sclLevel && $past(sclLevel) && !$past(startSeen) && !$past(stopSeen))
      |-> $stable(sdaOe));

endmodule

bind i2c_write_target i2cw_checker #(.WORD_W(8 * DATA_BYTES)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sclLevel (sclLevel),
  .startSeen(startSeen),
  .stopSeen (stopSeen),
  .sdaOe    (sdaOe),
  .wordValid(wordValid),
  .wordData (wordData)
);

// File: tb/i2c_write_target_test.sv
module i2c_write_target_test;

  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic [1:0] s0 = 2'd0, s1 = 2'd0, s2 = 2'd0;
  logic [1:0] liteS0 = 2'd1;
  logic oeMain, oeLite, wvMain, wvLite;
  logic [23:0] wdMain, wdLite;
  wire busSda = mSda & ~oeMain & ~oeLite;

  int vectors = 0, fails = 0;
  int mainWords = 0, liteWords = 0;
  logic [23:0] mainLast = '0, liteLast = '0;

  always #10 clk = ~clk;

  i2c_write_target uut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(busSda),
    .addrStrap0(s0), .addrStrap1(s1), .addrStrap2(s2),
    .sdaOe(oeMain), .wordValid(wvMain), .wordData(wdMain));

  i2c_write_target #(.FULL_STRAP(0)) uutLite (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(busSda),
    .addrStrap0(liteS0), .addrStrap1(2'd2), .addrStrap2(2'd1),
    .sdaOe(oeLite), .wordValid(wvLite), .wordData(wdLite));

  always @(negedge clk) begin
    if (wvMain) begin mainWords++; mainLast = wdMain; end
    if (wvLite) begin liteWords++; liteLast = wdLite; end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic int lvl(input logic [1:0] c);
    return (c == 2'd3) ? 2 : int'(c);
  endfunction

  function automatic logic [6:0] expAddr(input logic [1:0] a2, input logic [1:0] a1,
                                         input logic [1:0] a0);
    int i;
    i = 9 * lvl(a2) + 3 * lvl(a1) + lvl(a0);
    return 7'((i / 4 + 1) * 16 + i % 4);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; tick(Q); mScl = 1'b1; tick(Q); mSda = 1'b0; tick(Q); mScl = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    mSda = 1'b0; tick(Q); mScl = 1'b1; tick(Q); mSda = 1'b1; tick(Q);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      mSda = b[7 - i]; tick(Q); mScl = 1'b1; tick(2 * Q); mScl = 1'b0; tick(Q);
    end
  endtask

  task automatic ackSlot(output logic ackd);
    mSda = 1'b1; tick(Q); mScl = 1'b1; tick(Q);
    ackd = ~busSda;
    tick(Q); mScl = 1'b0; tick(Q);
    check("R11 release after ack clock", {31'd0, oeMain}, 32'd0);
  endtask

  // full frame with expected ack pattern and word output
  task automatic runFrame(input string tag, input logic [6:0] addr, input logic rw,
                          input int nBytes, input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] d2, input logic [7:0] d3, input logic [7:0] d4);
    logic [7:0] data [5];
    logic ackd;
    logic mainHit, liteHit;
    int mw0, lw0;
    data[0] = d0; data[1] = d1; data[2] = d2; data[3] = d3; data[4] = d4;
    mw0 = mainWords; lw0 = liteWords;
    mainHit = !rw && (addr == expAddr(s2, s1, s0) || addr == 7'h73);
    liteHit = !rw && (addr == 7'(16 + lvl(liteS0)) || addr == 7'h73);
    busStart();
    sendBits({addr, rw}, 8);
    ackSlot(ackd);
    check({tag, " address ack"}, {31'd0, ackd}, {31'd0, mainHit | liteHit});
    for (int k = 0; k < nBytes; k++) begin
      sendBits(data[k], 8);
      ackSlot(ackd);
      check(k < 3 ? "R7 data ack" : "R8 extra byte nak", {31'd0, ackd},
            {31'd0, (mainHit | liteHit) && (k < 3)});
    end
    busStop();
    tick(Q);
    check({tag, " R7 word count"}, 32'(mainWords - mw0), 32'(mainHit && nBytes >= 3));
    if (mainHit && nBytes >= 3)
      check("R7 R2 word value", {8'd0, mainLast}, {8'd0, data[0], data[1], data[2]});
    check({tag, " R10 lite word count"}, 32'(liteWords - lw0), 32'(liteHit && nBytes >= 3));
    if (liteHit && nBytes >= 3)
      check("R10 lite word value", {8'd0, liteLast}, {8'd0, data[0], data[1], data[2]});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic ackd;
    int mw0;
    void'($urandom(32'd4711));
    tick(5);
    // R1 reset state
    check("R1 sdaOe", {31'd0, oeMain}, 32'd0);
    check("R1 wordValid", {31'd0, wvMain}, 32'd0);
    check("R1 wordData", {8'd0, wdMain}, 32'd0);
    rstN = 1'b1;
    tick(5);

    // R3 local address with all-ground straps: 0x10
    s0 = 2'd0; s1 = 2'd0; s2 = 2'd0;
    runFrame("R3", 7'h10, 1'b0, 3, 8'hA5, 8'h3C, 8'h81, 8'h00, 8'h00);
    // R3 strap code 3 treated as supply: index 26 -> 0x72
    s0 = 2'd3; s1 = 2'd3; s2 = 2'd3;
    runFrame("R3", 7'h72, 1'b0, 3, 8'h01, 8'h80, 8'hFF, 8'h00, 8'h00);
    s0 = 2'd1; s1 = 2'd2; s2 = 2'd0;
    // R4 broadcast reaches both instances
    runFrame("R4", 7'h73, 1'b0, 3, 8'h12, 8'h34, 8'h56, 8'h00, 8'h00);
    // R5 foreign address
    runFrame("R5", 7'h55, 1'b0, 3, 8'hDE, 8'hAD, 8'hBE, 8'h00, 8'h00);
    // R6 read to local and broadcast
    runFrame("R6", expAddr(s2, s1, s0), 1'b1, 3, 8'h11, 8'h22, 8'h33, 8'h00, 8'h00);
    runFrame("R6", 7'h73, 1'b1, 2, 8'h11, 8'h22, 8'h33, 8'h00, 8'h00);
    // R8 five bytes, fourth and fifth refused
    runFrame("R8", expAddr(s2, s1, s0), 1'b0, 5, 8'hC0, 8'hFF, 8'hEE, 8'h77, 8'h66);
    // R10 reduced-strap instance at 0x11 (strap0 = open)
    runFrame("R10", 7'h11, 1'b0, 3, 8'h9A, 8'hBC, 8'hDE, 8'h00, 8'h00);

    // R9 stop inside a data byte
    mw0 = mainWords;
    busStart();
    sendBits({expAddr(s2, s1, s0), 1'b0}, 8); ackSlot(ackd);
    sendBits(8'h44, 8); ackSlot(ackd);
    sendBits(8'h55, 4);
    busStop(); tick(Q);
    check("R9 stop mid-byte no word", 32'(mainWords - mw0), 32'd0);
    check("R9 stop releases sdaOe", {31'd0, oeMain}, 32'd0);

    // R9 repeated start after one byte
    mw0 = mainWords;
    busStart();
    sendBits({expAddr(s2, s1, s0), 1'b0}, 8); ackSlot(ackd);
    sendBits(8'h99, 8); ackSlot(ackd);
    busStart();
    sendBits({expAddr(s2, s1, s0), 1'b0}, 8); ackSlot(ackd);
    check("R9 repeated start address ack", {31'd0, ackd}, 32'd1);
    sendBits(8'h0F, 8); ackSlot(ackd);
    sendBits(8'hF0, 8); ackSlot(ackd);
    sendBits(8'h5A, 8); ackSlot(ackd);
    busStop(); tick(Q);
    check("R9 one word after restart", 32'(mainWords - mw0), 32'd1);
    check("R9 word from restarted frame", {8'd0, mainLast}, {8'd0, 24'h0FF05A});

    // random frames
    for (int n = 0; n < 24; n++) begin
      logic [6:0] a;
      int pick;
      s0 = 2'($urandom); s1 = 2'($urandom); s2 = 2'($urandom);
      liteS0 = 2'($urandom);
      pick = int'($urandom % 4);
      case (pick)
        0: a = expAddr(s2, s1, s0);
        1: a = 7'h73;
        2: a = 7'(16 + lvl(liteS0));
        default: a = 7'($urandom);
      endcase
      runFrame("R3 R5 random", a, 1'(($urandom % 5) == 0), int'($urandom % 6),
               8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule